// File: doc/BRIEF.md
# RTU Frame Receiver with Silence Timing

This block sits behind a UART byte receiver on a serial field bus that uses the compact binary RTU framing. It splits the incoming byte stream into frames purely by line silence. A gap of 1.5 character times closes the reception window. A further 2.0 character times, 3.5 in all, close the frame. Both gap lengths arrive as clock counts on input ports, so one instance serves any baud rate.

During reception the block keeps the frame's bytes in a byte buffer through a simple write port, and only when the first byte names this node or the broadcast address. It keeps a running CRC-16 and counts the bytes. At the end of the frame it raises a one-cycle report strobe together with a set of error flags. It also emits one-cycle event pulses that a separate counter bank can accumulate. Request decoding and response generation belong downstream.

Top module: `rtuFrameReceiver`

## Requirements
- R1: After reset, no frame is accepted until `t35Clocks` consecutive cycles pass with no byte strobe. A strobe during this start-up wait restarts the wait. Such a byte is not written to the buffer and produces no frame report.
- R2: The first byte after idle opens a frame. It is written at buffer index 0 only when it equals `slaveAddr` or 0x00. Otherwise `wrongAddr` is set, and no byte of that frame is written, although every byte is still counted.
- R3: If the last byte strobe of a frame occurs in cycle N, the evaluation events pulse in cycle N + `t15Clocks`, and `frameReady` is high for exactly one cycle, cycle N + `t35Clocks`.
- R4: A byte strobe between the evaluation cycle and `frameReady` sets `frameErr`. It is not written and does not move the `frameReady` cycle.
- R5: The CRC-16 starts at 0xFFFF and processes each byte LSB first with the reflected polynomial 0xA001. The final two bytes of the frame carry the check value, low byte first. When the frame has at least 3 bytes and the check fails, `crcErr` is high at `frameReady`.
- R6: A frame of fewer than 3 bytes sets `shortFrame`, and `crcErr` stays low.
- R7: A strobe that carries the parity, framing or overrun error bit pulses `evParity`, `evFraming` or `evOverrun` in that same cycle. Once a frame is open, such a strobe also sets `frameErr` for that frame.
- R8: At most `BUF_DEPTH` bytes (83 by default) are counted and written. Each byte beyond that limit sets `overflow` and is not written, and `byteCount` stays at `BUF_DEPTH`.
- R9: In the evaluation cycle, a frame with no `frameErr`, not short and with a good CRC pulses `evBusMsg`. It also pulses `evSlaveMsg` when `wrongAddr` is low. Any other frame pulses `evCommErr` instead.
- R10: At reset, and in the cycle after `frameReady`, `byteCount` and all five flags are zero.
- R11: Each stored byte is presented on `bufWrData` with `bufWrEn` high during its own strobe cycle. `bufWrAddr` equals the byte's position in the frame, starting at 0. At `frameReady`, `byteCount` holds the number of bytes in the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| byteValid | input | 1 | One-cycle strobe: a received byte is on byteData |
| byteData | input | 8 | Received byte |
| parityErr | input | 1 | Parity error on this byte |
| framingErr | input | 1 | Stop-bit error on this byte |
| overrunErr | input | 1 | Receiver overrun on this byte |
| slaveAddr | input | 8 | Address of this node |
| t15Clocks | input | TIMER_W | 1.5-character silence, in clocks |
| t35Clocks | input | TIMER_W | 3.5-character silence, in clocks |
| bufWrEn | output | 1 | Buffer write enable |
| bufWrAddr | output | ADDR_W | Buffer write index |
| bufWrData | output | 8 | Buffer write data |
| byteCount | output | CNT_W | Bytes counted in the current frame |
| frameReady | output | 1 | One-cycle end-of-frame report |
| crcErr | output | 1 | CRC check failed |
| shortFrame | output | 1 | Frame had fewer than 3 bytes |
| frameErr | output | 1 | Line error or late byte |
| wrongAddr | output | 1 | Frame addressed to another node |
| overflow | output | 1 | Frame exceeded the buffer |
| evParity | output | 1 | Parity error event |
| evFraming | output | 1 | Framing error event |
| evOverrun | output | 1 | Overrun event |
| evBusMsg | output | 1 | Good frame on the bus |
| evSlaveMsg | output | 1 | Good frame for this node |
| evCommErr | output | 1 | Bad frame on the bus |

## Verification
The bench aims at the timing edges. It sends a second start-up byte after the 3.5-character point counted from reset but before that point counted from the first byte, so a wait that failed to restart would store it. It places a byte inside the 2.0-character window, where a design that restarted its timer or treated the byte as a new frame would move `frameReady` or write the byte. It also checks the exact report and event cycles against the last strobe, which exposes off-by-one timer limits. Foreign and broadcast addresses, a corrupted CRC byte, a two-byte frame and an 85-byte frame each target one flag: a wrong compare would store foreign data, raise a CRC error on a short frame, or write past the buffer.

// File: rtl/rtuRxPkg.sv
`timescale 1ns/1ps
package rtuRxPkg;

  localparam logic [15:0] CRC_SEED = 16'hFFFF;
  localparam logic [15:0] CRC_POLY = 16'hA001;

  typedef enum logic [1:0] {
    ST_INIT = 2'd0,
    ST_IDLE = 2'd1,
    ST_RECV = 2'd2,
    ST_WAIT = 2'd3
  } rxState_t;

  // strobes from the framing control to the datapath
  typedef struct packed {
    logic startFrame;  // first byte after idle
    logic addByte;     // further byte during reception
    logic evalFrame;   // 1.5-char silence reached: judge the frame
    logic lateByte;    // byte inside the 2.0-char wait window
    logic clearAll;    // return to idle: drop all frame state
  } ctlStrobes_t;

  // one byte of the reflected CRC-16, LSB first
  function automatic logic [15:0] crcStep(input logic [15:0] crcIn,
                                          input logic [7:0]  dataIn);
    logic [15:0] c;
    c = crcIn ^ {8'h00, dataIn};
    for (int i = 0; i < 8; i++) begin
      c = c[0] ? ((c >> 1) ^ CRC_POLY) : (c >> 1);
    end
    return c;
  endfunction

endpackage

// File: rtl/rtuRxControl.sv
`timescale 1ns/1ps
module rtuRxControl
  import rtuRxPkg::*;
#(
  parameter int TIMER_W = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               byteValid,
  input  logic [TIMER_W-1:0] t15Clocks,
  input  logic [TIMER_W-1:0] t35Clocks,
  output ctlStrobes_t        strobes,
  output logic               frameReady
);

  rxState_t           state, stateNext;
  logic [TIMER_W-1:0] tmr;
  logic [TIMER_W-1:0] limit;
  logic [TIMER_W:0]   tmrPlusOne;
  logic               expire;
  logic               tmrClear;

  // silence limit for the state being timed
  always_comb begin
    case (state)
      ST_INIT: limit = t35Clocks;
      ST_RECV: limit = t15Clocks;
      ST_WAIT: limit = t35Clocks - t15Clocks;
      default: limit = '0;
    endcase
  end

  assign tmrPlusOne = {1'b0, tmr} + {{TIMER_W{1'b0}}, 1'b1};
  assign expire     = tmrPlusOne >= {1'b0, limit};

  always_comb begin
    stateNext  = state;
    strobes    = '0;
    tmrClear   = 1'b0;
    frameReady = 1'b0;
    case (state)
      ST_INIT: begin
        if (byteValid) begin
          tmrClear = 1'b1;
        end else if (expire) begin
          stateNext        = ST_IDLE;
          strobes.clearAll = 1'b1;
          tmrClear         = 1'b1;
        end
      end
      ST_IDLE: begin
        tmrClear = 1'b1;
        if (byteValid) begin
          stateNext          = ST_RECV;
          strobes.startFrame = 1'b1;
        end
      end
      ST_RECV: begin
        if (byteValid) begin
          strobes.addByte = 1'b1;
          tmrClear        = 1'b1;
        end else if (expire) begin
          stateNext         = ST_WAIT;
          strobes.evalFrame = 1'b1;
          tmrClear          = 1'b1;
        end
      end
      default: begin  // ST_WAIT: timer is not restarted by bytes
        if (byteValid) begin
          strobes.lateByte = 1'b1;
        end
        if (expire) begin
          stateNext        = ST_IDLE;
          strobes.clearAll = 1'b1;
          frameReady       = 1'b1;
          tmrClear         = 1'b1;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_INIT;
      tmr   <= '0;
    end else begin
      state <= stateNext;
      tmr   <= tmrClear ? '0 : tmrPlusOne[TIMER_W-1:0];
    end
  end

endmodule

// File: rtl/rtuRxDatapath.sv
`timescale 1ns/1ps
module rtuRxDatapath
  import rtuRxPkg::*;
#(
  parameter int BUF_DEPTH = 83,
  parameter int ADDR_W    = 7,
  parameter int CNT_W     = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              byteValid,
  input  logic [7:0]        byteData,
  input  logic              parityErr,
  input  logic              framingErr,
  input  logic              overrunErr,
  input  logic [7:0]        slaveAddr,
  input  ctlStrobes_t       strobes,
  output logic              bufWrEn,
  output logic [ADDR_W-1:0] bufWrAddr,
  output logic [7:0]        bufWrData,
  output logic [CNT_W-1:0]  byteCount,
  output logic              crcErr,
  output logic              shortFrame,
  output logic              frameErr,
  output logic              wrongAddr,
  output logic              overflow,
  output logic              evParity,
  output logic              evFraming,
  output logic              evOverrun,
  output logic              evBusMsg,
  output logic              evSlaveMsg,
  output logic              evCommErr
);

  localparam logic [CNT_W-1:0] DEPTH_C   = CNT_W'(BUF_DEPTH);
  localparam logic [CNT_W-1:0] MIN_LEN_C = CNT_W'(3);
  localparam logic [CNT_W-1:0] ONE_C     = CNT_W'(1);

  logic [15:0] crcReg;
  logic        addrHit, roomLeft, byteBad;
  logic        lenShort, crcBad, frameGood;

  assign addrHit  = (byteData == slaveAddr) || (byteData == 8'h00);
  assign roomLeft = byteCount < DEPTH_C;
  assign byteBad  = parityErr | framingErr | overrunErr;

  // a frame carrying its own CRC leaves a zero residue
  assign lenShort  = byteCount < MIN_LEN_C;
  assign crcBad    = !lenShort && (crcReg != 16'h0000);
  assign frameGood = !frameErr && !lenShort && !crcBad;

  assign evParity   = byteValid && parityErr;
  assign evFraming  = byteValid && framingErr;
  assign evOverrun  = byteValid && overrunErr;
  assign evBusMsg   = strobes.evalFrame && frameGood;
  assign evSlaveMsg = strobes.evalFrame && frameGood && !wrongAddr;
  assign evCommErr  = strobes.evalFrame && !frameGood;

  assign bufWrEn   = (strobes.startFrame && addrHit) ||
                     (strobes.addByte && roomLeft && !wrongAddr);
  assign bufWrAddr = strobes.startFrame ? '0 : byteCount[ADDR_W-1:0];
  assign bufWrData = byteData;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      byteCount  <= '0;
      crcReg     <= CRC_SEED;
      crcErr     <= 1'b0;
      shortFrame <= 1'b0;
      frameErr   <= 1'b0;
      wrongAddr  <= 1'b0;
      overflow   <= 1'b0;
    end else if (strobes.clearAll) begin
      byteCount  <= '0;
      crcReg     <= CRC_SEED;
      crcErr     <= 1'b0;
      shortFrame <= 1'b0;
      frameErr   <= 1'b0;
      wrongAddr  <= 1'b0;
      overflow   <= 1'b0;
    end else begin
      if (strobes.startFrame) begin
        byteCount <= ONE_C;
        crcReg    <= crcStep(CRC_SEED, byteData);
        wrongAddr <= !addrHit;
        frameErr  <= byteBad;
        overflow  <= 1'b0;
      end
      if (strobes.addByte) begin
        crcReg   <= crcStep(crcReg, byteData);
        frameErr <= frameErr | byteBad;
        if (roomLeft) begin
          byteCount <= byteCount + ONE_C;
        end else begin
          overflow <= 1'b1;
        end
      end
      if (strobes.lateByte) begin
        frameErr <= 1'b1;
      end
      if (strobes.evalFrame) begin
        shortFrame <= lenShort;
        crcErr     <= crcBad;
      end
    end
  end

endmodule

// File: rtl/rtuFrameReceiver.sv
`timescale 1ns/1ps
module rtuFrameReceiver
  import rtuRxPkg::*;
#(
  parameter int BUF_DEPTH = 83,
  parameter int TIMER_W   = 16,
  localparam int ADDR_W   = $clog2(BUF_DEPTH),
  localparam int CNT_W    = $clog2(BUF_DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               byteValid,
  input  logic [7:0]         byteData,
  input  logic               parityErr,
  input  logic               framingErr,
  input  logic               overrunErr,
  input  logic [7:0]         slaveAddr,
  input  logic [TIMER_W-1:0] t15Clocks,
  input  logic [TIMER_W-1:0] t35Clocks,
  output logic               bufWrEn,
  output logic [ADDR_W-1:0]  bufWrAddr,
  output logic [7:0]         bufWrData,
  output logic [CNT_W-1:0]   byteCount,
  output logic               frameReady,
  output logic               crcErr,
  output logic               shortFrame,
  output logic               frameErr,
  output logic               wrongAddr,
  output logic               overflow,
  output logic               evParity,
  output logic               evFraming,
  output logic               evOverrun,
  output logic               evBusMsg,
  output logic               evSlaveMsg,
  output logic               evCommErr
);

  ctlStrobes_t strobes;

  rtuRxControl #(.TIMER_W(TIMER_W)) u_control (
    .clk        (clk),
    .rstN       (rstN),
    .byteValid  (byteValid),
    .t15Clocks  (t15Clocks),
    .t35Clocks  (t35Clocks),
    .strobes    (strobes),
    .frameReady (frameReady)
  );

  rtuRxDatapath #(
    .BUF_DEPTH (BUF_DEPTH),
    .ADDR_W    (ADDR_W),
    .CNT_W     (CNT_W)
  ) u_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .byteValid  (byteValid),
    .byteData   (byteData),
    .parityErr  (parityErr),
    .framingErr (framingErr),
    .overrunErr (overrunErr),
    .slaveAddr  (slaveAddr),
    .strobes    (strobes),
    .bufWrEn    (bufWrEn),
    .bufWrAddr  (bufWrAddr),
    .bufWrData  (bufWrData),
    .byteCount  (byteCount),
    .crcErr     (crcErr),
    .shortFrame (shortFrame),
    .frameErr   (frameErr),
    .wrongAddr  (wrongAddr),
    .overflow   (overflow),
    .evParity   (evParity),
    .evFraming  (evFraming),
    .evOverrun  (evOverrun),
    .evBusMsg   (evBusMsg),
    .evSlaveMsg (evSlaveMsg),
    .evCommErr  (evCommErr)
  );

endmodule

// File: rtl/rtuRxChecker.sv
`timescale 1ns/1ps
module rtuRxChecker #(
  parameter int BUF_DEPTH = 83,
  parameter int ADDR_W    = 7,
  parameter int CNT_W     = 7
) (
  input logic              clk,
  input logic              rstN,
  input logic              bufWrEn,
  input logic [ADDR_W-1:0] bufWrAddr,
  input logic [CNT_W-1:0]  byteCount,
  input logic              frameReady,
  input logic              crcErr,
  input logic              shortFrame,
  input logic              frameErr,
  input logic              wrongAddr,
  input logic              overflow,
  input logic              evBusMsg,
  input logic              evSlaveMsg,
  input logic              evCommErr
);

  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(BUF_DEPTH);

  AST_WRITE_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    bufWrEn |-> (CNT_W'(bufWrAddr) < DEPTH_C)); // R8

  AST_NO_WRITE_AFTER_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    overflow |-> !bufWrEn); // R8

  AST_COUNT_CAPPED: assert property (@(posedge clk) disable iff (!rstN)
    byteCount <= DEPTH_C); // R8

  AST_FOREIGN_NOT_STORED: assert property (@(posedge clk) disable iff (!rstN)
    (bufWrEn && (bufWrAddr != '0)) |-> !wrongAddr); // R2

  AST_SLAVE_NEEDS_BUS: assert property (@(posedge clk) disable iff (!rstN)
    evSlaveMsg |-> evBusMsg); // R9

  AST_GOOD_BAD_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    evBusMsg |-> !evCommErr); // R9

  AST_SHORT_NOT_CRC: assert property (@(posedge clk) disable iff (!rstN)
    shortFrame |-> !crcErr); // R6

  AST_REPORT_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    frameReady |=> !frameReady); // R3

  AST_CLEAR_AFTER_REPORT: assert property (@(posedge clk) disable iff (!rstN)
    frameReady |=> (!crcErr && !shortFrame && !frameErr && !wrongAddr &&
                    !overflow && (byteCount == '0))); // R10

  AST_FRAME_ERR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (frameErr && !frameReady) |=> frameErr); // R7

endmodule

bind rtuFrameReceiver rtuRxChecker #(
  .BUF_DEPTH (BUF_DEPTH),
  .ADDR_W    (ADDR_W),
  .CNT_W     (CNT_W)
) u_rtuRxChecker (
  .clk        (clk),
  .rstN       (rstN),
  .bufWrEn    (bufWrEn),
  .bufWrAddr  (bufWrAddr),
  .byteCount  (byteCount),
  .frameReady (frameReady),
  .crcErr     (crcErr),
  .shortFrame (shortFrame),
  .frameErr   (frameErr),
  .wrongAddr  (wrongAddr),
  .overflow   (overflow),
  .evBusMsg   (evBusMsg),
  .evSlaveMsg (evSlaveMsg),
  .evCommErr  (evCommErr)
);

// File: tb/rtuFrameReceiver_bench.sv
`timescale 1ns/1ps
module rtuFrameReceiver_bench;

  localparam int DEPTH = 83;
  localparam int TW    = 16;
  localparam int AW    = $clog2(DEPTH);
  localparam int CW    = $clog2(DEPTH + 1);
  localparam int T15   = 20;
  localparam int T35   = 46;
  localparam int GAP   = 4;
  localparam logic [7:0] MY_ADDR = 8'h0A;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          byteValid = 1'b0;
  logic [7:0]    byteData = 8'h00;
  logic          parityErr = 1'b0, framingErr = 1'b0, overrunErr = 1'b0;
  logic [TW-1:0] t15Clocks = TW'(T15);
  logic [TW-1:0] t35Clocks = TW'(T35);
  logic          bufWrEn;
  logic [AW-1:0] bufWrAddr;
  logic [7:0]    bufWrData;
  logic [CW-1:0] byteCount;
  logic          frameReady, crcErr, shortFrame, frameErr, wrongAddr, overflow;
  logic          evParity, evFraming, evOverrun, evBusMsg, evSlaveMsg, evCommErr;

  rtuFrameReceiver #(.BUF_DEPTH(DEPTH), .TIMER_W(TW)) u_rtuFrameReceiver (
    .clk(clk), .rstN(rstN), .byteValid(byteValid), .byteData(byteData),
    .parityErr(parityErr), .framingErr(framingErr), .overrunErr(overrunErr),
    .slaveAddr(MY_ADDR), .t15Clocks(t15Clocks), .t35Clocks(t35Clocks),
    .bufWrEn(bufWrEn), .bufWrAddr(bufWrAddr), .bufWrData(bufWrData),
    .byteCount(byteCount), .frameReady(frameReady), .crcErr(crcErr),
    .shortFrame(shortFrame), .frameErr(frameErr), .wrongAddr(wrongAddr),
    .overflow(overflow), .evParity(evParity), .evFraming(evFraming),
    .evOverrun(evOverrun), .evBusMsg(evBusMsg), .evSlaveMsg(evSlaveMsg),
    .evCommErr(evCommErr)
  );

  always #2.5 clk = ~clk;  // 200 MHz

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // monitor: samples outputs at the falling edge
  logic [7:0] wrMem [0:127];
  int wrTotal = 0, rptTotal = 0, busTotal = 0, slaveTotal = 0, commTotal = 0;
  int parTotal = 0, frmTotal = 0, ovrTotal = 0;
  int postSeen = 0, postBad = 0;
  int rptCyc = 0, busCyc = 0, evalCyc = 0, rptCount = 0;
  bit rCrc, rShort, rFrame, rWrong, rOvf;
  bit prevReady = 1'b0;

  always @(negedge clk) begin
    if (bufWrEn) begin
      wrMem[bufWrAddr] = bufWrData;
      wrTotal++;
    end
    if (prevReady) begin
      postSeen++;
      if (crcErr || shortFrame || frameErr || wrongAddr || overflow || byteCount != '0)
        postBad++;
    end
    prevReady = frameReady;
    if (frameReady) begin
      rptTotal++;
      rptCyc   = cyc;
      rptCount = int'(byteCount);
      rCrc = crcErr; rShort = shortFrame; rFrame = frameErr;
      rWrong = wrongAddr; rOvf = overflow;
    end
    if (evBusMsg)   begin busTotal++; busCyc = cyc; end
    if (evSlaveMsg) slaveTotal++;
    if (evCommErr)  commTotal++;
    if (evBusMsg || evCommErr) evalCyc = cyc;
    if (evParity)  parTotal++;
    if (evFraming) frmTotal++;
    if (evOverrun) ovrTotal++;
  end

  int checks = 0, errors = 0;
  bit done = 1'b0;

  task automatic checkEq(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // frame under construction and its per-byte error bits
  logic [7:0] fb [0:127];
  bit eP [0:127];
  bit eF [0:127];
  bit eO [0:127];
  int lastByteCyc = 0;

  // snapshots of the monitor totals
  int sWr, sRpt, sBus, sSlave, sComm, sPar, sFrm, sOvr, sPostSeen, sPostBad;

  task automatic snap();
    sWr = wrTotal; sRpt = rptTotal; sBus = busTotal; sSlave = slaveTotal;
    sComm = commTotal; sPar = parTotal; sFrm = frmTotal; sOvr = ovrTotal;
    sPostSeen = postSeen; sPostBad = postBad;
  endtask

  function automatic logic [15:0] benchCrc(input int n);
    logic [15:0] c = 16'hFFFF;
    for (int i = 0; i < n; i++) begin
      for (int b = 0; b < 8; b++) begin
        logic fbk;
        fbk = c[0] ^ fb[i][b];
        c = c >> 1;
        if (fbk) c = c ^ 16'hA001;
      end
    end
    return c;
  endfunction

  task automatic clearErrBits();
    for (int i = 0; i < 128; i++) begin eP[i] = 0; eF[i] = 0; eO[i] = 0; end
  endtask

  task automatic loadRequest(input logic [7:0] addr);
    fb[0] = addr; fb[1] = 8'h03; fb[2] = 8'h00; fb[3] = 8'h02;
    fb[4] = 8'h00; fb[5] = 8'h02;
  endtask

  task automatic appendCrc(input int n);
    logic [15:0] c;
    c = benchCrc(n);
    fb[n]     = c[7:0];
    fb[n + 1] = c[15:8];
  endtask

  task automatic sendByte(input logic [7:0] d, input bit p, input bit f, input bit o);
    @(posedge clk); #1;
    byteValid = 1'b1; byteData = d; parityErr = p; framingErr = f; overrunErr = o;
    lastByteCyc = cyc;
    @(posedge clk); #1;
    byteValid = 1'b0; parityErr = 1'b0; framingErr = 1'b0; overrunErr = 1'b0;
    repeat (GAP - 2) @(posedge clk);
  endtask

  task automatic sendFrame(input int n);
    for (int i = 0; i < n; i++) sendByte(fb[i], eP[i], eF[i], eO[i]);
  endtask

  task automatic waitReport(input string tag);
    int k = 0;
    while (rptTotal == sRpt && k < 400) begin
      @(posedge clk);
      k++;
    end
    checkEq({tag, " report seen"}, rptTotal - sRpt, 1);
    repeat (3) @(posedge clk);
  endtask

  task automatic checkStored(input string tag, input int n);
    int bad = 0;
    for (int i = 0; i < n; i++) if (wrMem[i] !== fb[i]) bad++;
    checkEq({tag, " stored bytes match"}, bad, 0);
  endtask

  // ---------------- scenarios ----------------
  task automatic testReset();
    @(negedge clk);
    checkEq("R10 reset count", int'(byteCount), 0);
    checkEq("R10 reset flags", int'({crcErr, shortFrame, frameErr, wrongAddr, overflow, frameReady}), 0);
  endtask

  task automatic testStartup();
    snap();
    repeat (8) @(posedge clk);
    sendByte(MY_ADDR, 0, 0, 0);          // inside the start-up wait
    repeat (40 - GAP) @(posedge clk);    // past 46 from reset, not from this byte
    sendByte(MY_ADDR, 0, 0, 0);
    repeat (120) @(posedge clk);
    checkEq("R1 start-up bytes not written", wrTotal - sWr, 0);
    checkEq("R1 start-up no report", rptTotal - sRpt, 0);
  endtask

  task automatic testGood();
    clearErrBits(); loadRequest(MY_ADDR); appendCrc(6);
    snap(); sendFrame(8); waitReport("R3 good");
    checkEq("R11 good write count", wrTotal - sWr, 8);
    checkStored("R11 good", 8);
    checkEq("R11 good byteCount", rptCount, 8);
    checkEq("R3 report cycle", rptCyc - lastByteCyc, T35);
    checkEq("R3 evaluation cycle", busCyc - lastByteCyc, T15);
    checkEq("R5 good crcErr", int'(rCrc), 0);
    checkEq("R5 good other flags", int'({rShort, rFrame, rWrong, rOvf}), 0);
    checkEq("R9 good bus event", busTotal - sBus, 1);
    checkEq("R9 good slave event", slaveTotal - sSlave, 1);
    checkEq("R9 good no comm error", commTotal - sComm, 0);
    checkEq("R10 cleared after good", postBad - sPostBad, 0);
    checkEq("R10 post-report sampled", postSeen - sPostSeen, 1);
  endtask

  task automatic testBroadcast();
    clearErrBits(); loadRequest(8'h00); appendCrc(6);
    snap(); sendFrame(8); waitReport("R2 broadcast");
    checkEq("R2 broadcast stored", wrTotal - sWr, 8);
    checkStored("R2 broadcast", 8);
    checkEq("R2 broadcast wrongAddr", int'(rWrong), 0);
    checkEq("R9 broadcast slave event", slaveTotal - sSlave, 1);
  endtask

  task automatic testForeign();
    clearErrBits(); loadRequest(8'h0B); appendCrc(6);
    snap(); sendFrame(8); waitReport("R2 foreign");
    checkEq("R2 foreign not stored", wrTotal - sWr, 0);
    checkEq("R2 foreign wrongAddr", int'(rWrong), 1);
    checkEq("R2 foreign counted", rptCount, 8);
    checkEq("R9 foreign bus event", busTotal - sBus, 1);
    checkEq("R9 foreign no slave event", slaveTotal - sSlave, 0);
  endtask

  task automatic testCrcBad();
    clearErrBits(); loadRequest(MY_ADDR); appendCrc(6);
    fb[7] = fb[7] ^ 8'h01;
    snap(); sendFrame(8); waitReport("R5 bad crc");
    checkEq("R5 crcErr set", int'(rCrc), 1);
    checkEq("R9 bad crc comm event", commTotal - sComm, 1);
    checkEq("R9 bad crc no bus event", busTotal - sBus, 0);
    checkEq("R10 cleared after bad crc", postBad - sPostBad, 0);
  endtask

  task automatic testShort();
    clearErrBits(); fb[0] = MY_ADDR; fb[1] = 8'h03;
    snap(); sendFrame(2); waitReport("R6 short");
    checkEq("R6 shortFrame set", int'(rShort), 1);
    checkEq("R6 no crcErr on short", int'(rCrc), 0);
    checkEq("R6 short counted", rptCount, 2);
    checkEq("R9 short comm event", commTotal - sComm, 1);
  endtask

  task automatic testLineErrors();
    clearErrBits(); loadRequest(MY_ADDR); appendCrc(6);
    eP[2] = 1; eF[4] = 1; eO[6] = 1;
    snap(); sendFrame(8); waitReport("R7 line errors");
    clearErrBits();
    checkEq("R7 parity event", parTotal - sPar, 1);
    checkEq("R7 framing event", frmTotal - sFrm, 1);
    checkEq("R7 overrun event", ovrTotal - sOvr, 1);
    checkEq("R7 frameErr set", int'(rFrame), 1);
    checkEq("R7 crc still good", int'(rCrc), 0);
    checkEq("R9 line error comm event", commTotal - sComm, 1);
    checkEq("R9 line error no bus event", busTotal - sBus, 0);
  endtask

  task automatic testLate();
    int lastCyc;
    clearErrBits(); loadRequest(MY_ADDR); appendCrc(6);
    snap(); sendFrame(8);
    lastCyc = lastByteCyc;
    while (cyc < lastCyc + T15 + 5) @(posedge clk);
    sendByte(8'h55, 0, 0, 0);
    waitReport("R4 late byte");
    checkEq("R4 late byte sets frameErr", int'(rFrame), 1);
    checkEq("R4 report cycle unchanged", rptCyc - lastCyc, T35);
    checkEq("R4 late byte not written", wrTotal - sWr, 8);
    checkEq("R4 evaluation before late byte was good", busTotal - sBus, 1);
    checkEq("R4 late byte count unchanged", rptCount, 8);
  endtask

  task automatic testOverflow();
    clearErrBits();
    fb[0] = MY_ADDR;
    for (int i = 1; i < DEPTH + 2; i++) fb[i] = 8'(i * 7 + 3);
    snap(); sendFrame(DEPTH + 2); waitReport("R8 overflow");
    checkEq("R8 writes capped", wrTotal - sWr, DEPTH);
    checkStored("R8 overflow", DEPTH);
    checkEq("R8 overflow flag", int'(rOvf), 1);
    checkEq("R8 count capped", rptCount, DEPTH);
    checkEq("R10 cleared after overflow", postBad - sPostBad, 0);
  endtask

  initial begin
    clearErrBits();
    repeat (4) @(posedge clk);
    #1 rstN = 1'b1;
    testReset();
    testStartup();
    testGood();
    testBroadcast();
    testForeign();
    testCrcBad();
    testShort();
    testLineErrors();
    testLate();
    testOverflow();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule